// File: doc/BRIEF.md
# Multi-Instruction Register Rename Map Table

This block renames a group of `N_SLOTS` instructions in every clock cycle. Each instruction slot carries two logical source registers, one logical destination register and a fresh physical tag taken from an external free-list port. A directly indexed map holds the current physical tag of every logical register. In a single cycle the block does four things:

- it reads the source mappings and the mappings that the destinations are about to replace;
- it writes the new destination mappings;
- it forwards mappings between slots of the same group;
- it returns every displaced tag on a per-slot free output.

A checkpoint stack of fixed depth sits beside each map entry as a shift register. A push saves the whole mapping so that branch recovery can later reload it in one cycle. The free-list storage and the commit logic are outside this block. Source and free outputs are combinational in the same cycle as the inputs.

Top module: `rename_map`

## Requirements
- R1: After reset, every logical register r maps to physical tag r, and every checkpoint level also holds this identity mapping.
- R2: When no earlier valid slot in the group writes its logical register, a source tag output gives the map contents for that register in the same cycle. Slot 0 always reads the map.
- R3: When a source of slot i matches the destination of a valid earlier slot j < i, the source tag output is the new tag of slot j.
- R4: When a source matches several earlier valid destinations, the highest-numbered (latest) of those slots supplies the tag.
- R5: For each valid slot, `free_vld_o[i]` is 1 and `free_tag_o` slot i gives the tag its destination held before this slot, in the same cycle.
- R6: If an earlier valid slot in the group writes the same destination, the displaced tag returned by slot i is that earlier slot's new tag.
- R7: When several valid slots write one logical register, the entry holds the new tag of the latest such slot after the clock edge.
- R8: An invalid slot writes nothing, forwards nothing and has `free_vld_o` low. A cycle with no valid slot and no restore leaves the map unchanged.
- R9: `ckpt_push_i` saves the mapping as it stands after that cycle's writes into level 0, and shifts each older level down by one. The entry in level `DEPTH-1` is discarded.
- R10: `ckpt_restore_i` loads the level selected by `ckpt_sel_i` into the map, where level 0 is the newest. It takes priority over renaming and pushing: in that cycle no slot writes or forwards, all `free_vld_o` bits are 0, and the stack is unchanged.
- R11: A mapping written in one cycle is seen by slot 0 reads in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_vld_i | input | N_SLOTS | Per-slot valid, bit i = slot i (fetch order) |
| src_a_i | input | N_SLOTS*LOG_W | First logical source per slot, slot i at bits [i*LOG_W +: LOG_W] |
| src_b_i | input | N_SLOTS*LOG_W | Second logical source per slot |
| dst_i | input | N_SLOTS*LOG_W | Logical destination per slot |
| new_tag_i | input | N_SLOTS*TAG_W | Fresh physical tag per slot from the free list |
| ckpt_push_i | input | 1 | Save mapping after this cycle's writes |
| ckpt_restore_i | input | 1 | Reload mapping from a saved level |
| ckpt_sel_i | input | SEL_W | Level to reload, 0 = newest |
| src_a_tag_o | output | N_SLOTS*TAG_W | Physical tag for first source per slot |
| src_b_tag_o | output | N_SLOTS*TAG_W | Physical tag for second source per slot |
| free_vld_o | output | N_SLOTS | Displaced tag valid per slot |
| free_tag_o | output | N_SLOTS*TAG_W | Displaced tag per slot |

## Verification
The bound checker checks several properties on every cycle. It checks that slot 1 picks up slot 0's new tag for a matching source and for a matching destination. It also checks that a restore silences every free output, that a write by the latest slot is read back by slot 0 on the next cycle, and that an idle cycle leaves a read unchanged. Other behaviours need the bench's directed scenarios and its in-order reference model to show. These are priority among three or more writers of one register, the ignoring of a slot that is not valid, and the shift and reload of checkpoint levels over many cycles. Pushes and restores mixed with colliding random groups are also left to the bench.

// File: rtl/rename_pkg.sv
package rename_pkg;
  typedef enum logic [1:0] {
    CK_HOLD = 2'd0,
    CK_PUSH = 2'd1,
    CK_LOAD = 2'd2
  } ckpt_op_e;
endpackage

// File: rtl/rename_ckpt_col.sv
// Checkpoint shift register for one map entry; level 0 is newest.
module rename_ckpt_col #(
  parameter int               TAG_W = 6,
  parameter int               DEPTH = 4,
  parameter int               SEL_W = 2,
  parameter logic [TAG_W-1:0] INIT  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [TAG_W-1:0] q_o
);
  logic [TAG_W-1:0] stk_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) stk_q[d] <= INIT;
    end else if (push_i) begin
      stk_q[0] <= d_i;
      for (int d = 1; d < DEPTH; d++) stk_q[d] <= stk_q[d-1];
    end
  end

  assign q_o = stk_q[sel_i];
endmodule

// File: rtl/rename_map_ram.sv
// Map storage: N_RD read ports, N_WR write ports, later port wins.
module rename_map_ram
  import rename_pkg::*;
#(
  parameter int N_LOG = 32,
  parameter int LOG_W = 5,
  parameter int TAG_W = 6,
  parameter int N_RD  = 12,
  parameter int N_WR  = 4,
  parameter int DEPTH = 4,
  parameter int SEL_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_RD*LOG_W-1:0] rd_addr_i,
  output logic [N_RD*TAG_W-1:0] rd_data_o,
  input  logic [N_WR-1:0]       wr_en_i,
  input  logic [N_WR*LOG_W-1:0] wr_addr_i,
  input  logic [N_WR*TAG_W-1:0] wr_data_i,
  input  ckpt_op_e              op_i,
  input  logic [SEL_W-1:0]      sel_i
);
  logic [TAG_W-1:0] map_q   [N_LOG];
  logic [TAG_W-1:0] map_nxt [N_LOG];
  logic [TAG_W-1:0] ck_q    [N_LOG];
  logic             push;

  assign push = (op_i == CK_PUSH);

  always_comb begin
    for (int e = 0; e < N_LOG; e++)
      map_nxt[e] = (op_i == CK_LOAD) ? ck_q[e] : map_q[e];
    if (op_i != CK_LOAD) begin
      for (int w = 0; w < N_WR; w++)
        if (wr_en_i[w]) map_nxt[wr_addr_i[w*LOG_W +: LOG_W]] = wr_data_i[w*TAG_W +: TAG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_LOG; e++) map_q[e] <= TAG_W'(e);
    end else begin
      for (int e = 0; e < N_LOG; e++) map_q[e] <= map_nxt[e];
    end
  end

  for (genvar e = 0; e < N_LOG; e++) begin : g_col
    rename_ckpt_col #(
      .TAG_W(TAG_W), .DEPTH(DEPTH), .SEL_W(SEL_W), .INIT(TAG_W'(e))
    ) u_col (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .push_i(push),
      .d_i   (map_nxt[e]),
      .sel_i (sel_i),
      .q_o   (ck_q[e])
    );
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_data_o[r*TAG_W +: TAG_W] = map_q[rd_addr_i[r*LOG_W +: LOG_W]];
  end
endmodule

// File: rtl/rename_fwd.sv
// Intra-group bypass for one read port of slot SLOT: latest earlier writer wins.
module rename_fwd #(
  parameter int N_SLOTS = 4,
  parameter int LOG_W   = 5,
  parameter int TAG_W   = 6,
  parameter int SLOT    = 0
) (
  input  logic [LOG_W-1:0]         lreg_i,
  input  logic [TAG_W-1:0]         ram_tag_i,
  input  logic [N_SLOTS-1:0]       wr_vld_i,
  input  logic [N_SLOTS*LOG_W-1:0] wr_dst_i,
  input  logic [N_SLOTS*TAG_W-1:0] wr_tag_i,
  output logic [TAG_W-1:0]         tag_o
);
  always_comb begin
    tag_o = ram_tag_i;
    for (int j = 0; j < N_SLOTS; j++)
      if (j < SLOT && wr_vld_i[j] && wr_dst_i[j*LOG_W +: LOG_W] == lreg_i)
        tag_o = wr_tag_i[j*TAG_W +: TAG_W];
  end
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int N_LOG   = 32,
  parameter int N_PHYS  = 64,
  parameter int DEPTH   = 4,
  localparam int LOG_W  = $clog2(N_LOG),
  localparam int TAG_W  = $clog2(N_PHYS),
  localparam int SEL_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SLOTS-1:0]       slot_vld_i,
  input  logic [N_SLOTS*LOG_W-1:0] src_a_i,
  input  logic [N_SLOTS*LOG_W-1:0] src_b_i,
  input  logic [N_SLOTS*LOG_W-1:0] dst_i,
  input  logic [N_SLOTS*TAG_W-1:0] new_tag_i,
  input  logic                     ckpt_push_i,
  input  logic                     ckpt_restore_i,
  input  logic [SEL_W-1:0]         ckpt_sel_i,
  output logic [N_SLOTS*TAG_W-1:0] src_a_tag_o,
  output logic [N_SLOTS*TAG_W-1:0] src_b_tag_o,
  output logic [N_SLOTS-1:0]       free_vld_o,
  output logic [N_SLOTS*TAG_W-1:0] free_tag_o
);
  localparam int N_RD = 3 * N_SLOTS;

  logic [N_SLOTS-1:0]    wr_en;
  logic [N_RD*LOG_W-1:0] rd_addr;
  logic [N_RD*TAG_W-1:0] rd_data;
  ckpt_op_e              op;

  // restore wins over rename and push
  assign wr_en = slot_vld_i & {N_SLOTS{~ckpt_restore_i}};
  assign op    = ckpt_restore_i ? CK_LOAD : (ckpt_push_i ? CK_PUSH : CK_HOLD);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    assign rd_addr[(3*i)*LOG_W   +: LOG_W] = src_a_i[i*LOG_W +: LOG_W];
    assign rd_addr[(3*i+1)*LOG_W +: LOG_W] = src_b_i[i*LOG_W +: LOG_W];
    assign rd_addr[(3*i+2)*LOG_W +: LOG_W] = dst_i[i*LOG_W +: LOG_W];

    rename_fwd #(.N_SLOTS(N_SLOTS), .LOG_W(LOG_W), .TAG_W(TAG_W), .SLOT(i)) u_fwd_a (
      .lreg_i   (src_a_i[i*LOG_W +: LOG_W]),
      .ram_tag_i(rd_data[(3*i)*TAG_W +: TAG_W]),
      .wr_vld_i (wr_en),
      .wr_dst_i (dst_i),
      .wr_tag_i (new_tag_i),
      .tag_o    (src_a_tag_o[i*TAG_W +: TAG_W])
    );
    rename_fwd #(.N_SLOTS(N_SLOTS), .LOG_W(LOG_W), .TAG_W(TAG_W), .SLOT(i)) u_fwd_b (
      .lreg_i   (src_b_i[i*LOG_W +: LOG_W]),
      .ram_tag_i(rd_data[(3*i+1)*TAG_W +: TAG_W]),
      .wr_vld_i (wr_en),
      .wr_dst_i (dst_i),
      .wr_tag_i (new_tag_i),
      .tag_o    (src_b_tag_o[i*TAG_W +: TAG_W])
    );
    // displaced tag also sees earlier writers of the same destination
    rename_fwd #(.N_SLOTS(N_SLOTS), .LOG_W(LOG_W), .TAG_W(TAG_W), .SLOT(i)) u_fwd_d (
      .lreg_i   (dst_i[i*LOG_W +: LOG_W]),
      .ram_tag_i(rd_data[(3*i+2)*TAG_W +: TAG_W]),
      .wr_vld_i (wr_en),
      .wr_dst_i (dst_i),
      .wr_tag_i (new_tag_i),
      .tag_o    (free_tag_o[i*TAG_W +: TAG_W])
    );
  end

  assign free_vld_o = wr_en;

  rename_map_ram #(
    .N_LOG(N_LOG), .LOG_W(LOG_W), .TAG_W(TAG_W), .N_RD(N_RD),
    .N_WR(N_SLOTS), .DEPTH(DEPTH), .SEL_W(SEL_W)
  ) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .wr_en_i  (wr_en),
    .wr_addr_i(dst_i),
    .wr_data_i(new_tag_i),
    .op_i     (op),
    .sel_i    (ckpt_sel_i)
  );
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int N_SLOTS = 4,
  parameter int LOG_W   = 5,
  parameter int TAG_W   = 6,
  parameter int SEL_W   = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_SLOTS-1:0]       slot_vld_i,
  input logic [N_SLOTS*LOG_W-1:0] src_a_i,
  input logic [N_SLOTS*LOG_W-1:0] src_b_i,
  input logic [N_SLOTS*LOG_W-1:0] dst_i,
  input logic [N_SLOTS*TAG_W-1:0] new_tag_i,
  input logic                     ckpt_push_i,
  input logic                     ckpt_restore_i,
  input logic [SEL_W-1:0]         ckpt_sel_i,
  input logic [N_SLOTS*TAG_W-1:0] src_a_tag_o,
  input logic [N_SLOTS*TAG_W-1:0] src_b_tag_o,
  input logic [N_SLOTS-1:0]       free_vld_o,
  input logic [N_SLOTS*TAG_W-1:0] free_tag_o
);
  localparam int L = N_SLOTS - 1;

  a_r10_restore_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_restore_i |-> (free_vld_o == '0));

  a_r11_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ckpt_restore_i && slot_vld_i[L]) |=>
      (!(slot_vld_i[0] && src_a_i[0 +: LOG_W] == $past(dst_i[L*LOG_W +: LOG_W]))
       || src_a_tag_o[0 +: TAG_W] == $past(new_tag_i[L*TAG_W +: TAG_W])));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i == '0 && !ckpt_restore_i) |=>
      (src_a_i[0 +: LOG_W] != $past(src_a_i[0 +: LOG_W])
       || src_a_tag_o[0 +: TAG_W] == $past(src_a_tag_o[0 +: TAG_W])));

  if (N_SLOTS > 1) begin : g_pair
    a_r3_fwd_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ckpt_restore_i && slot_vld_i[0] && slot_vld_i[1]
       && src_a_i[LOG_W +: LOG_W] == dst_i[0 +: LOG_W])
      |-> src_a_tag_o[TAG_W +: TAG_W] == new_tag_i[0 +: TAG_W]);

    a_r6_fwd_old_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ckpt_restore_i && slot_vld_i[0] && slot_vld_i[1]
       && dst_i[LOG_W +: LOG_W] == dst_i[0 +: LOG_W])
      |-> (free_vld_o[1] && free_tag_o[TAG_W +: TAG_W] == new_tag_i[0 +: TAG_W]));
  end
endmodule

bind rename_map rename_map_chk #(
  .N_SLOTS(N_SLOTS), .LOG_W(LOG_W), .TAG_W(TAG_W), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/sim_rename_map.sv
`timescale 1ns/1ps
module sim_rename_map;
  localparam int N  = 4;
  localparam int LW = 5;
  localparam int TW = 6;
  localparam int NL = 32;
  localparam int D  = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [N-1:0]    vld_p;
  logic [N*LW-1:0] sa_p, sb_p, ds_p;
  logic [N*TW-1:0] nt_p;
  logic            push_p, rest_p;
  logic [1:0]      sel_p;
  logic [N*TW-1:0] sat_o, sbt_o, ft_o;
  logic [N-1:0]    fv_o;

  rename_map #(.N_SLOTS(N), .N_LOG(NL), .N_PHYS(64), .DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slot_vld_i(vld_p), .src_a_i(sa_p), .src_b_i(sb_p),
    .dst_i(ds_p), .new_tag_i(nt_p), .ckpt_push_i(push_p), .ckpt_restore_i(rest_p),
    .ckpt_sel_i(sel_p), .src_a_tag_o(sat_o), .src_b_tag_o(sbt_o),
    .free_vld_o(fv_o), .free_tag_o(ft_o));

  int n_run = 0, n_fail = 0;
  bit s_v [N];
  int s_a [N], s_b [N], s_d [N], s_t [N];
  int tag_ctr = 40;
  logic [TW-1:0] ref_map [NL];
  logic [TW-1:0] ref_stk [D][NL];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_slots();
    for (int i = 0; i < N; i++) begin
      s_v[i] = 0; s_a[i] = 0; s_b[i] = 0; s_d[i] = 0; s_t[i] = 0;
    end
  endtask

  task automatic set_slot(input int i, input bit v, input int a, input int b, input int d);
    s_v[i] = v; s_a[i] = a; s_b[i] = b; s_d[i] = d;
    s_t[i] = tag_ctr; tag_ctr = (tag_ctr + 7) % 64;
  endtask

  // one group: drive at negedge, check before posedge, update model at posedge
  task automatic cyc(input string req, input bit push, input bit rest, input int sel);
    logic [TW-1:0] tmp [NL];
    int ea, eb, ef;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      vld_p[i] = s_v[i];
      sa_p[i*LW +: LW] = LW'(s_a[i]);
      sb_p[i*LW +: LW] = LW'(s_b[i]);
      ds_p[i*LW +: LW] = LW'(s_d[i]);
      nt_p[i*TW +: TW] = TW'(s_t[i]);
    end
    push_p = push; rest_p = rest; sel_p = 2'(sel);
    #2;
    tmp = ref_map;
    for (int i = 0; i < N; i++) begin
      ea = tmp[s_a[i]]; eb = tmp[s_b[i]]; ef = tmp[s_d[i]];
      chk(req, $sformatf("slot%0d src_a", i), int'(sat_o[i*TW +: TW]), ea);
      chk(req, $sformatf("slot%0d src_b", i), int'(sbt_o[i*TW +: TW]), eb);
      chk(req, $sformatf("slot%0d free_vld", i), int'(fv_o[i]), int'(s_v[i] && !rest));
      if (s_v[i] && !rest) begin
        chk(req, $sformatf("slot%0d free_tag", i), int'(ft_o[i*TW +: TW]), ef);
        tmp[s_d[i]] = TW'(s_t[i]);
      end
    end
    @(posedge clk);
    if (rest) ref_map = ref_stk[sel];
    else begin
      ref_map = tmp;
      if (push) begin
        for (int d = D-1; d > 0; d--) ref_stk[d] = ref_stk[d-1];
        ref_stk[0] = tmp;
      end
    end
  endtask

  // read every register through slot 0 source ports, no writes
  task automatic sweep(input string req);
    for (int r = 0; r < NL; r += 2) begin
      clr_slots();
      s_a[0] = r; s_b[0] = r + 1;
      cyc(req, 0, 0, 0);
    end
  endtask

  task automatic t_reset();
    sweep("R1");
  endtask

  task automatic t_independent();
    clr_slots();
    set_slot(0, 1, 1, 2, 3); set_slot(1, 1, 4, 5, 6);
    set_slot(2, 1, 7, 8, 9); set_slot(3, 1, 10, 11, 12);
    cyc("R5", 0, 0, 0);
    clr_slots();
    set_slot(0, 1, 3, 6, 13); set_slot(1, 1, 9, 12, 14);
    cyc("R11", 0, 0, 0);
    sweep("R2");
  endtask

  task automatic t_forward();
    clr_slots();
    set_slot(0, 1, 1, 2, 20); set_slot(1, 1, 20, 3, 21);
    set_slot(2, 1, 21, 20, 22); set_slot(3, 1, 22, 21, 23);
    cyc("R3", 0, 0, 0);
  endtask

  task automatic t_multi();
    clr_slots();
    set_slot(0, 1, 0, 0, 5); set_slot(1, 1, 5, 0, 5);
    set_slot(2, 1, 5, 5, 5); set_slot(3, 1, 5, 5, 6);
    cyc("R4", 0, 0, 0);
  endtask

  task automatic t_same_dst();
    clr_slots();
    for (int i = 0; i < N; i++) set_slot(i, 1, 2, 3, 9);
    cyc("R6", 0, 0, 0);
    clr_slots();
    s_a[0] = 9; s_b[0] = 5;
    cyc("R7", 0, 0, 0);
  endtask

  task automatic t_invalid();
    clr_slots();
    set_slot(0, 1, 1, 1, 15); set_slot(1, 0, 1, 1, 3);
    set_slot(2, 1, 3, 15, 16); set_slot(3, 0, 3, 3, 16);
    cyc("R8", 0, 0, 0);
    clr_slots();
    s_a[0] = 3; s_b[0] = 16;
    cyc("R8", 0, 0, 0);
  endtask

  task automatic t_ckpt();
    clr_slots();
    set_slot(0, 1, 1, 2, 24); set_slot(3, 1, 24, 1, 25);
    cyc("R9", 1, 0, 0);
    clr_slots();
    set_slot(0, 1, 24, 25, 24); set_slot(1, 1, 0, 0, 26);
    cyc("R9", 1, 0, 0);
    clr_slots();
    set_slot(0, 1, 0, 0, 24); set_slot(2, 1, 0, 0, 25);
    cyc("R9", 0, 0, 0);
    clr_slots();
    cyc("R9", 0, 1, 1);
    sweep("R9");
  endtask

  task automatic t_restore_prio();
    clr_slots();
    for (int i = 0; i < N; i++) set_slot(i, 1, i, 24, 24 + i);
    cyc("R10", 1, 1, 0);
    sweep("R10");
    clr_slots();
    cyc("R10", 0, 1, 3);
    sweep("R10");
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      int mode;
      clr_slots();
      for (int i = 0; i < N; i++)
        set_slot(i, ($urandom % 4) != 0, $urandom % 8, $urandom % 8, $urandom % 8);
      mode = $urandom % 10;
      cyc("R11", mode == 0 || mode == 1, mode == 2, $urandom % D);
    end
    sweep("R11");
  endtask

  initial begin
    for (int r = 0; r < NL; r++) begin
      ref_map[r] = TW'(r);
      for (int d = 0; d < D; d++) ref_stk[d][r] = TW'(r);
    end
    vld_p = '0; sa_p = '0; sb_p = '0; ds_p = '0; nt_p = '0;
    push_p = 0; rest_p = 0; sel_p = '0;
    clr_slots();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_independent();
    t_forward();
    t_multi();
    t_same_dst();
    t_invalid();
    t_ckpt();
    t_restore_prio();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule